// File: doc/BRIEF.md
# Byte-Swapping Halfword DMA Bridge

This block sits between a 16-bit network peripheral and 32-bit-addressed system memory. The peripheral asks for a transfer by giving a 24-bit buffer offset, a byte length, a direction and a flag that turns swapping off. The bridge builds the full memory address by ORing the offset into a high-address value held elsewhere. It then issues burst commands on a command/data memory port. Data moves one 16-bit halfword per beat. Peripheral write data flows through combinationally to the memory write channel. Memory read data comes back to the peripheral one register stage later.

In the normal (swapping) mode the two bytes of every halfword are exchanged in both directions. Address and length are forced even before anything is issued. Memory writes are cut into bursts of at most 64 bytes, and each burst starts 64 bytes above the previous one. With swapping turned off, data passes untouched. The address keeps its low bit, an odd length rounds up to a final beat that enables only the low byte lane, and the whole transfer goes out as a single burst. A one-cycle completion pulse follows the last beat. An empty transfer completes without touching memory.

Top module: `dma16_swap_bridge`

## Requirements
- R1: The first burst address equals the zero-extended offset ORed with `hi_addr_i`, sampled when the request is accepted; with swapping off, bit 0 of that result is kept.
- R2: With swapping on (`req_noswap_i`=0), bit 0 of the burst address is 0 and the transfer moves floor(len/2) halfword beats.
- R3: With swapping on, each write beat's `mem_wdata_o` is `{per_wdata_i[7:0], per_wdata_i[15:8]}`.
- R4: With swapping on, each read beat's `per_rdata_o` is `{mem_rdata_i[7:0], mem_rdata_i[15:8]}` of the beat returned one cycle earlier, and `per_rvalid_o` pulses one cycle after each `mem_rvalid_i` of the transfer.
- R5: With swapping off, data passes unchanged in both directions and the transfer moves ceil(len/2) beats. `mem_wbe_o` is 2'b11 on every beat, except the final beat of an odd length, where it is 2'b01 (bit 0 = low byte lane).
- R6: Swapped writes are split into bursts of min(32, remaining) beats. Each burst address is the previous one plus 64.
- R7: Reads (either mode) and unswapped writes are issued as one burst that covers the whole transfer.
- R8: `req_ready_o` is 1 only while the bridge is idle. A request is taken on a cycle with `req_valid_i` and `req_ready_o` both high, and no burst is issued while `req_ready_o` is 1.
- R9: `done_o` is a one-cycle pulse in the cycle after the final beat's handshake. A transfer of zero beats (len 0, or len 1 with swapping on) raises `done_o` in the cycle after acceptance, with no burst.
- R10: A burst command holds its valid, address and beat count until `mem_cmd_ready_i` accepts it. `mem_wlast_o` marks the last write beat of each burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hi_addr_i | input | ADDR_W | High-address value ORed into every transfer |
| req_valid_i | input | 1 | Transfer request valid |
| req_ready_o | output | 1 | Bridge idle, request can be taken |
| req_write_i | input | 1 | 1 = peripheral to memory, 0 = memory to peripheral |
| req_offset_i | input | OFF_W | Buffer offset from the peripheral |
| req_len_i | input | LEN_W | Transfer length in bytes |
| req_noswap_i | input | 1 | 1 = no byte swap and no even forcing |
| per_wvalid_i | input | 1 | Peripheral write halfword valid |
| per_wready_o | output | 1 | Write halfword taken |
| per_wdata_i | input | 16 | Peripheral write halfword |
| per_rvalid_o | output | 1 | Read halfword valid for the peripheral |
| per_rdata_o | output | 16 | Read halfword for the peripheral |
| mem_cmd_valid_o | output | 1 | Burst command valid |
| mem_cmd_ready_i | input | 1 | Burst command accepted |
| mem_cmd_we_o | output | 1 | Burst is a memory write |
| mem_cmd_addr_o | output | ADDR_W | Burst byte address |
| mem_cmd_beats_o | output | LEN_W | Burst length in halfword beats |
| mem_wvalid_o | output | 1 | Memory write beat valid |
| mem_wready_i | input | 1 | Memory write beat accepted |
| mem_wdata_o | output | 16 | Memory write halfword |
| mem_wbe_o | output | 2 | Byte enables of the write beat |
| mem_wlast_o | output | 1 | Last beat of the current burst |
| mem_rvalid_i | input | 1 | Memory read beat valid |
| mem_rdata_i | input | 16 | Memory read halfword |
| done_o | output | 1 | Transfer complete pulse |

## Verification
The assertions assume that memory returns read beats only after it has accepted a read burst, and never more beats than that burst requested. They also assume that `mem_cmd_ready_i` and `mem_wready_i` may stall for any number of cycles. The bench's memory model keeps to this. It queues one address per accepted read beat and raises `mem_rvalid_i` only while that queue holds entries. It holds requests until `req_ready_o` is seen, and it only drives write data that belongs to the transfer in flight. The command and write-ready inputs follow fixed stall patterns, so the hold-until-accepted and burst-boundary checks see real back-pressure.

// File: rtl/dma16_pkg.sv
package dma16_pkg;

  localparam int BEAT_W     = 16;
  localparam int BEAT_BYTES = BEAT_W / 8;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CMD  = 2'd1,
    ST_DATA = 2'd2,
    ST_FIN  = 2'd3
  } xfer_state_t;

endpackage

// File: rtl/dma16_req_align.sv
// Turns a raw request into a base address, a beat count and a tail flag.
module dma16_req_align #(
  parameter int OFF_W  = 24,
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16
) (
  input  logic [OFF_W-1:0]  offset_i,
  input  logic [ADDR_W-1:0] hi_addr_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic              noswap_i,
  output logic [ADDR_W-1:0] base_addr_o,
  output logic [LEN_W-1:0]  beats_o,
  output logic              odd_tail_o
);

  logic [ADDR_W-1:0] merged;
  logic [LEN_W-1:0]  half_len;

  always_comb begin
    merged   = ADDR_W'(offset_i) | hi_addr_i;
    half_len = len_i >> 1;
    if (noswap_i) begin
      base_addr_o = merged;
      beats_o     = half_len + LEN_W'(len_i[0]);
      odd_tail_o  = len_i[0];
    end else begin
      base_addr_o = {merged[ADDR_W-1:1], 1'b0};
      beats_o     = half_len;
      odd_tail_o  = 1'b0;
    end
  end

endmodule

// File: rtl/dma16_lane_swap.sv
// Exchanges the two bytes of every halfword in a word unless bypassed.
module dma16_lane_swap #(
  parameter int WORD_W = 16
) (
  input  logic              bypass_i,
  input  logic [WORD_W-1:0] data_i,
  output logic [WORD_W-1:0] data_o
);

  localparam int NUM_HW = WORD_W / 16;

  logic [WORD_W-1:0] swapped;

  for (genvar h = 0; h < NUM_HW; h++) begin : g_hw
    assign swapped[h*16 +: 8]     = data_i[h*16 + 8 +: 8];
    assign swapped[h*16 + 8 +: 8] = data_i[h*16 +: 8];
  end

  assign data_o = bypass_i ? data_i : swapped;

endmodule

// File: rtl/dma16_burst_ctl.sv
// Sequencer: accepts a request, issues bursts, counts beats, signals completion.
module dma16_burst_ctl
  import dma16_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int LEN_W       = 16,
  parameter int CHUNK_BEATS = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid_i,
  input  logic              req_we_i,
  input  logic              req_noswap_i,
  input  logic [ADDR_W-1:0] base_addr_i,
  input  logic [LEN_W-1:0]  total_beats_i,
  input  logic              odd_tail_i,
  output logic              req_ready_o,
  output logic              cmd_valid_o,
  output logic              cmd_we_o,
  output logic [ADDR_W-1:0] cmd_addr_o,
  output logic [LEN_W-1:0]  cmd_beats_o,
  input  logic              cmd_ready_i,
  input  logic              beat_fire_i,
  output logic              data_phase_o,
  output logic              burst_last_o,
  output logic              tail_beat_o,
  output logic              noswap_o,
  output logic              done_o
);

  localparam logic [LEN_W-1:0] CHUNK_CAP = LEN_W'(CHUNK_BEATS);

  xfer_state_t       state_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  rem_q;
  logic [LEN_W-1:0]  cnt_q;
  logic              odd_q;
  logic              noswap_q;
  logic              we_q;
  logic              chunk_en;
  logic              cmd_fire;

  assign chunk_en    = we_q & ~noswap_q;
  assign cmd_beats_o = (chunk_en && (rem_q > CHUNK_CAP)) ? CHUNK_CAP : rem_q;
  assign cmd_fire    = (state_q == ST_CMD) && cmd_ready_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      addr_q   <= '0;
      rem_q    <= '0;
      cnt_q    <= '0;
      odd_q    <= 1'b0;
      noswap_q <= 1'b0;
      we_q     <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (req_valid_i) begin
            addr_q   <= base_addr_i;
            rem_q    <= total_beats_i;
            odd_q    <= odd_tail_i;
            noswap_q <= req_noswap_i;
            we_q     <= req_we_i;
            state_q  <= (total_beats_i == '0) ? ST_FIN : ST_CMD;
          end
        end
        ST_CMD: begin
          if (cmd_fire) begin
            cnt_q   <= cmd_beats_o;
            rem_q   <= rem_q - cmd_beats_o;
            addr_q  <= addr_q + ADDR_W'({cmd_beats_o, 1'b0});
            state_q <= ST_DATA;
          end
        end
        ST_DATA: begin
          if (beat_fire_i) begin
            cnt_q <= cnt_q - 1'b1;
            if (cnt_q == LEN_W'(1)) begin
              state_q <= (rem_q == '0) ? ST_FIN : ST_CMD;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o  = (state_q == ST_IDLE);
  assign cmd_valid_o  = (state_q == ST_CMD);
  assign cmd_we_o     = we_q;
  assign cmd_addr_o   = addr_q;
  assign data_phase_o = (state_q == ST_DATA);
  assign burst_last_o = (cnt_q == LEN_W'(1));
  assign tail_beat_o  = odd_q && (rem_q == '0) && (cnt_q == LEN_W'(1));
  assign noswap_o     = noswap_q;
  assign done_o       = (state_q == ST_FIN);

  // R10: command is held until accepted
  p_cmd_hold_r10: assert property (@(posedge clk) disable iff (rst)
    cmd_valid_o && !cmd_ready_i |=> cmd_valid_o && $stable(cmd_addr_o) && $stable(cmd_beats_o));

  // R2: swapped bursts start on an even byte address
  p_even_addr_r2: assert property (@(posedge clk) disable iff (rst)
    cmd_valid_o && !noswap_q |-> !cmd_addr_o[0]);

  // R6: swapped write bursts are non-empty and capped
  p_chunk_cap_r6: assert property (@(posedge clk) disable iff (rst)
    cmd_valid_o && we_q && !noswap_q |-> (cmd_beats_o <= CHUNK_CAP) && (cmd_beats_o != '0));

  // R9: completion is a single-cycle pulse followed by idle
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o && req_ready_o);

  // R8: an accepted request makes the bridge busy
  p_busy_after_accept_r8: assert property (@(posedge clk) disable iff (rst)
    req_valid_i && req_ready_o |=> !req_ready_o);

endmodule

// File: rtl/dma16_swap_bridge.sv
module dma16_swap_bridge
  import dma16_pkg::*;
#(
  parameter int OFF_W       = 24,
  parameter int ADDR_W      = 32,
  parameter int LEN_W       = 16,
  parameter int CHUNK_BYTES = 64
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [ADDR_W-1:0]     hi_addr_i,
  input  logic                  req_valid_i,
  output logic                  req_ready_o,
  input  logic                  req_write_i,
  input  logic [OFF_W-1:0]      req_offset_i,
  input  logic [LEN_W-1:0]      req_len_i,
  input  logic                  req_noswap_i,
  input  logic                  per_wvalid_i,
  output logic                  per_wready_o,
  input  logic [BEAT_W-1:0]     per_wdata_i,
  output logic                  per_rvalid_o,
  output logic [BEAT_W-1:0]     per_rdata_o,
  output logic                  mem_cmd_valid_o,
  input  logic                  mem_cmd_ready_i,
  output logic                  mem_cmd_we_o,
  output logic [ADDR_W-1:0]     mem_cmd_addr_o,
  output logic [LEN_W-1:0]      mem_cmd_beats_o,
  output logic                  mem_wvalid_o,
  input  logic                  mem_wready_i,
  output logic [BEAT_W-1:0]     mem_wdata_o,
  output logic [BEAT_BYTES-1:0] mem_wbe_o,
  output logic                  mem_wlast_o,
  input  logic                  mem_rvalid_i,
  input  logic [BEAT_W-1:0]     mem_rdata_i,
  output logic                  done_o
);

  localparam int CHUNK_BEATS = CHUNK_BYTES / BEAT_BYTES;

  logic [ADDR_W-1:0] base_addr;
  logic [LEN_W-1:0]  total_beats;
  logic              odd_tail;
  logic              data_phase;
  logic              burst_last;
  logic              tail_beat;
  logic              noswap_q;
  logic              beat_fire;
  logic              rd_beat;
  logic [BEAT_W-1:0] rd_lane;

  dma16_req_align #(
    .OFF_W (OFF_W),
    .ADDR_W(ADDR_W),
    .LEN_W (LEN_W)
  ) u_align (
    .offset_i   (req_offset_i),
    .hi_addr_i  (hi_addr_i),
    .len_i      (req_len_i),
    .noswap_i   (req_noswap_i),
    .base_addr_o(base_addr),
    .beats_o    (total_beats),
    .odd_tail_o (odd_tail)
  );

  dma16_burst_ctl #(
    .ADDR_W     (ADDR_W),
    .LEN_W      (LEN_W),
    .CHUNK_BEATS(CHUNK_BEATS)
  ) u_ctl (
    .clk          (clk),
    .rst          (rst),
    .req_valid_i  (req_valid_i),
    .req_we_i     (req_write_i),
    .req_noswap_i (req_noswap_i),
    .base_addr_i  (base_addr),
    .total_beats_i(total_beats),
    .odd_tail_i   (odd_tail),
    .req_ready_o  (req_ready_o),
    .cmd_valid_o  (mem_cmd_valid_o),
    .cmd_we_o     (mem_cmd_we_o),
    .cmd_addr_o   (mem_cmd_addr_o),
    .cmd_beats_o  (mem_cmd_beats_o),
    .cmd_ready_i  (mem_cmd_ready_i),
    .beat_fire_i  (beat_fire),
    .data_phase_o (data_phase),
    .burst_last_o (burst_last),
    .tail_beat_o  (tail_beat),
    .noswap_o     (noswap_q),
    .done_o       (done_o)
  );

  // Write path: peripheral halfword straight through the lane swapper.
  dma16_lane_swap #(.WORD_W(BEAT_W)) u_wr_swap (
    .bypass_i(noswap_q),
    .data_i  (per_wdata_i),
    .data_o  (mem_wdata_o)
  );

  assign mem_wvalid_o = data_phase & mem_cmd_we_o & per_wvalid_i;
  assign per_wready_o = data_phase & mem_cmd_we_o & mem_wready_i;
  assign mem_wlast_o  = burst_last;
  assign mem_wbe_o    = tail_beat ? BEAT_BYTES'(1) : '1;

  // Read path: swap then register toward the peripheral.
  dma16_lane_swap #(.WORD_W(BEAT_W)) u_rd_swap (
    .bypass_i(noswap_q),
    .data_i  (mem_rdata_i),
    .data_o  (rd_lane)
  );

  assign rd_beat   = data_phase & ~mem_cmd_we_o & mem_rvalid_i;
  assign beat_fire = mem_cmd_we_o ? (mem_wvalid_o & mem_wready_i) : rd_beat;

  always_ff @(posedge clk) begin
    if (rst) begin
      per_rvalid_o <= 1'b0;
    end else begin
      per_rvalid_o <= rd_beat;
    end
    per_rdata_o <= rd_lane;
  end

  // R4: swapped read data is the byte-exchanged beat of the previous cycle
  p_rd_swap_r4: assert property (@(posedge clk) disable iff (rst)
    per_rvalid_o && !noswap_q |-> per_rdata_o == {$past(mem_rdata_i[7:0]), $past(mem_rdata_i[15:8])});

  // R5: unswapped read data is passed unchanged
  p_rd_pass_r5: assert property (@(posedge clk) disable iff (rst)
    per_rvalid_o && noswap_q |-> per_rdata_o == $past(mem_rdata_i));

  // R9: completion follows a final beat or an empty request, never a mid-transfer beat
  p_done_after_beat_r9: assert property (@(posedge clk) disable iff (rst)
    done_o |-> $past(beat_fire) || $past(req_valid_i && req_ready_o));

endmodule

// File: tb/dma16_swap_bridge_tb.sv
module dma16_swap_bridge_tb;

  localparam int OFF_W  = 24;
  localparam int ADDR_W = 32;
  localparam int LEN_W  = 16;

  typedef struct packed {
    logic        we;
    logic [31:0] addr;
    logic [15:0] beats;
  } cmd_t;

  typedef struct packed {
    logic [15:0] d;
    logic [1:0]  be;
    logic        last;
  } wb_t;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [ADDR_W-1:0] hi_addr_i = '0;
  logic              req_valid_i = 1'b0;
  logic              req_ready_o;
  logic              req_write_i = 1'b0;
  logic [OFF_W-1:0]  req_offset_i = '0;
  logic [LEN_W-1:0]  req_len_i = '0;
  logic              req_noswap_i = 1'b0;
  logic              per_wvalid_i = 1'b0;
  logic              per_wready_o;
  logic [15:0]       per_wdata_i = '0;
  logic              per_rvalid_o;
  logic [15:0]       per_rdata_o;
  logic              mem_cmd_valid_o;
  logic              mem_cmd_ready_i = 1'b0;
  logic              mem_cmd_we_o;
  logic [ADDR_W-1:0] mem_cmd_addr_o;
  logic [LEN_W-1:0]  mem_cmd_beats_o;
  logic              mem_wvalid_o;
  logic              mem_wready_i = 1'b0;
  logic [15:0]       mem_wdata_o;
  logic [1:0]        mem_wbe_o;
  logic              mem_wlast_o;
  logic              mem_rvalid_i = 1'b0;
  logic [15:0]       mem_rdata_i = '0;
  logic              done_o;

  dma16_swap_bridge u_dut (.*);

  always #2 clk = ~clk;

  cmd_t        exp_cmd[$];
  wb_t         exp_w[$];
  logic [15:0] exp_r[$];
  logic [15:0] src_w[$];
  logic [31:0] rd_pend[$];

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int last_fire_cyc = -10;
  int done_cnt = 0;
  logic w_fire_q = 1'b0;
  logic r_fire_q = 1'b0;

  function automatic logic [15:0] mem_fn(input logic [31:0] a);
    return {a[7:0] ^ 8'h5A, a[15:8] ^ 8'hC3};
  endfunction

  function automatic logic [15:0] sw(input logic [15:0] d);
    return {d[7:0], d[15:8]};
  endfunction

  task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Memory / peripheral stimulus, updated just after each rising edge.
  always @(posedge clk) begin
    cyc <= cyc + 1;
    #1;
    if (w_fire_q && src_w.size() > 0) void'(src_w.pop_front());
    if (r_fire_q && rd_pend.size() > 0) void'(rd_pend.pop_front());
    w_fire_q = 1'b0;
    r_fire_q = 1'b0;
    per_wvalid_i    = (src_w.size() > 0);
    per_wdata_i     = (src_w.size() > 0) ? src_w[0] : 16'h0;
    mem_rvalid_i    = (rd_pend.size() > 0) && ((cyc % 5) != 3);
    mem_rdata_i     = (rd_pend.size() > 0) ? mem_fn(rd_pend[0]) : 16'h0;
    mem_cmd_ready_i = (cyc % 3) != 1;
    mem_wready_i    = (cyc % 4) != 2;
  end

  // Scoreboard monitor, sampling mid-cycle.
  always @(negedge clk) begin
    if (!rst) begin
      if (mem_cmd_valid_o && mem_cmd_ready_i) begin
        cmd_t got;
        got = '{we: mem_cmd_we_o, addr: mem_cmd_addr_o, beats: mem_cmd_beats_o};
        chk(req_ready_o == 1'b0, "R8 ready while bursting", 64'(req_ready_o), 64'd0);
        if (exp_cmd.size() == 0) begin
          chk(1'b0, "R9 unexpected burst", 64'(got), 64'd0);
        end else begin
          cmd_t e;
          e = exp_cmd.pop_front();
          chk(got == e, "R1/R6/R7 burst command", 64'(got), 64'(e));
        end
        if (!mem_cmd_we_o)
          for (int i = 0; i < int'(mem_cmd_beats_o); i++)
            rd_pend.push_back(mem_cmd_addr_o + 32'(2 * i));
      end
      if (mem_wvalid_o && mem_wready_i) begin
        wb_t got;
        got = '{d: mem_wdata_o, be: mem_wbe_o, last: mem_wlast_o};
        w_fire_q = 1'b1;
        chk(per_wready_o == 1'b1, "R10 write handshake", 64'(per_wready_o), 64'd1);
        if (exp_w.size() == 0) begin
          chk(1'b0, "R3 unexpected write beat", 64'(got), 64'd0);
        end else begin
          wb_t e;
          e = exp_w.pop_front();
          chk(got == e, "R3/R5/R10 write beat", 64'(got), 64'(e));
          if (exp_w.size() == 0) last_fire_cyc = cyc;
        end
      end
      if (mem_rvalid_i && rd_pend.size() > 0) begin
        r_fire_q = 1'b1;
        if (rd_pend.size() == 1) last_fire_cyc = cyc;
      end
      if (per_rvalid_o) begin
        if (exp_r.size() == 0) begin
          chk(1'b0, "R4 unexpected read beat", 64'(per_rdata_o), 64'd0);
        end else begin
          logic [15:0] e;
          e = exp_r.pop_front();
          chk(per_rdata_o == e, "R4/R5 read data", 64'(per_rdata_o), 64'(e));
        end
      end
      if (done_o) begin
        done_cnt++;
        chk(cyc == last_fire_cyc + 1, "R9 done timing", 64'(cyc), 64'(last_fire_cyc + 1));
      end
    end
  end

  task automatic run(input logic we, input logic [23:0] off, input int len,
                     input logic ns, input logic [31:0] hi, input logic [7:0] seed);
    logic [31:0] base;
    int          beats;
    int          d0;
    bit          chunked;
    base    = {8'h00, off} | hi;
    if (!ns) base[0] = 1'b0;
    beats   = ns ? (len + 1) / 2 : len / 2;
    chunked = we && !ns;
    if (beats > 0) begin
      if (chunked) begin
        for (int k = 0; k * 32 < beats; k++) begin
          int n;
          n = (beats - k * 32 > 32) ? 32 : beats - k * 32;
          exp_cmd.push_back('{we: 1'b1, addr: base + 32'(64 * k), beats: 16'(n)});
        end
      end else begin
        exp_cmd.push_back('{we: we, addr: base, beats: 16'(beats)});
      end
    end
    for (int i = 0; i < beats; i++) begin
      if (we) begin
        logic [15:0] p;
        wb_t         e;
        p = {seed + 8'(2 * i), seed + 8'(2 * i + 1)};
        src_w.push_back(p);
        e.d    = ns ? p : sw(p);
        e.be   = (ns && (len % 2 == 1) && i == beats - 1) ? 2'b01 : 2'b11;
        e.last = chunked ? ((i % 32) == 31 || i == beats - 1) : (i == beats - 1);
        exp_w.push_back(e);
      end else begin
        logic [15:0] m;
        m = mem_fn(base + 32'(2 * i));
        exp_r.push_back(ns ? m : sw(m));
      end
    end
    @(negedge clk);
    hi_addr_i    = hi;
    req_write_i  = we;
    req_offset_i = off;
    req_len_i    = 16'(len);
    req_noswap_i = ns;
    req_valid_i  = 1'b1;
    d0 = done_cnt;
    while (!req_ready_o) @(negedge clk);
    if (beats == 0) last_fire_cyc = cyc;
    @(negedge clk);
    req_valid_i = 1'b0;
    for (int t = 0; t < 5000 && done_cnt == d0; t++) @(negedge clk);
    chk(done_cnt == d0 + 1, "R9 completion seen", 64'(done_cnt - d0), 64'd1);
    chk(exp_cmd.size() == 0 && exp_w.size() == 0 && exp_r.size() == 0,
        "R7 all expected items consumed",
        64'(exp_cmd.size() + exp_w.size() + exp_r.size()), 64'd0);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    chk(req_ready_o == 1'b1, "R8 reset ready", 64'(req_ready_o), 64'd1);
    chk(done_o == 1'b0 && mem_cmd_valid_o == 1'b0 && per_rvalid_o == 1'b0 && mem_wvalid_o == 1'b0,
        "R9 reset outputs quiet", 64'({done_o, mem_cmd_valid_o, per_rvalid_o, mem_wvalid_o}), 64'd0);
    // R1/R5: unswapped write, odd address kept, even length
    run(1'b1, 24'h000123, 6, 1'b1, 32'h4000_0000, 8'h10);
    // R5: unswapped write, odd length -> low-lane tail beat
    run(1'b1, 24'h000201, 7, 1'b1, 32'h4000_0000, 8'h30);
    // R1: OR of overlapping bits, unswapped
    run(1'b1, 24'h000111, 2, 1'b1, 32'h0000_0101, 8'h50);
    // R2/R3: swapped write, odd address and length forced even
    run(1'b1, 24'h000345, 9, 1'b0, 32'h4000_0000, 8'h70);
    // R6: swapped write split into 32,32,11 beats
    run(1'b1, 24'h001000, 150, 1'b0, 32'h8000_0000, 8'h01);
    // R6: exactly one full chunk
    run(1'b1, 24'h002000, 64, 1'b0, 32'h8000_0000, 8'h80);
    // R6: 65 bytes -> 32 beats after even forcing
    run(1'b1, 24'h002101, 65, 1'b0, 32'h8000_0000, 8'h90);
    // R4/R2: swapped read, odd address
    run(1'b0, 24'h000777, 10, 1'b0, 32'h2000_0000, 8'h00);
    // R5/R7: unswapped read, odd length, one burst
    run(1'b0, 24'h000501, 5, 1'b1, 32'h2000_0000, 8'h00);
    // R7: long swapped read stays one burst
    run(1'b0, 24'h003000, 200, 1'b0, 32'h0000_0F00, 8'h00);
    // R9: zero-beat transfers
    run(1'b1, 24'h000010, 0, 1'b0, 32'h0, 8'h00);
    run(1'b1, 24'h000010, 1, 1'b0, 32'h0, 8'h00);
    run(1'b0, 24'h000010, 0, 1'b1, 32'h0, 8'h00);
    // R5: single byte unswapped write
    run(1'b1, 24'h0000F0, 1, 1'b1, 32'h0000_0F00, 8'hA0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R9 watchdog actual=timeout expected=completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule